// File: doc/BRIEF.md
# Serial Two-Wire EEPROM Slave Controller

This block is the slave side of a two-wire serial memory. It watches a clock line and a data line, recognises its device-select byte, and gives access to a 256-byte array that stands in for non-volatile cells. It supports these operations:

- a single-byte write;
- a page write of up to 16 bytes;
- a read at the current address;
- a random read, which sets the address and then issues a repeated start into a read;
- sequential reads that run across the whole array.

The data line is open drain. The block only ever pulls it low, and the board pull-up provides the high level.

Written bytes first collect in a page buffer. They reach the array only when a stop condition ends the write. That stop also begins a timed write cycle. For the length of that cycle the controller ignores the bus and will not acknowledge its own address. A supply-good input gates every commit: while the supply is low, written data is dropped and no write cycle starts. Both bus lines pass through two-flop synchronisers and are oversampled by the system clock. Start and stop conditions are recognised as data-line edges while the clock line is high.

Top module: `serial_eeprom_slave`

## Requirements
- R1: While reset is asserted and right after it, the data line is released (`sda_pull` = 0).
- R2: A device-select byte whose upper four bits are 1010 is acknowledged, whatever bits 3..1 hold. Bit 0 selects the direction: 1 is read and 0 is write. Any other prefix is not acknowledged, and the block then ignores the bus until the next start.
- R3: A write of one data byte, ended by a stop, stores that byte at the word address that was sent.
- R4: In a page write, only the low four address bits advance, and they wrap inside the 16-byte page. A later byte at the same offset replaces an earlier one. Bytes outside the page are left unchanged.
- R5: A write that ends with a repeated start, rather than a stop, changes no memory and starts no write cycle. The address pointer still advances as though the data had been accepted.
- R6: After a committing stop, the device-select byte is not acknowledged for `WR_CYCLES` clocks. After that it is acknowledged again.
- R7: If `supply_ok` is low at the stop, the memory is not changed and no write cycle starts.
- R8: A read at the current address returns the byte that follows the last byte accessed.
- R9: A random read returns the byte at the word address sent in the dummy write.
- R10: A sequential read advances across page boundaries and wraps from address 0xFF to 0x00.
- R11: The block pulls the data line low only after a clock-line fall. It never begins pulling while the clock line is high.
- R12: When the master does not acknowledge a read byte, the block releases the data line and stops sending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| supply_ok | input | 1 | High when the supply is above the reset threshold; low blocks commits |
| sda_pull | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The bench exercises the write path in several ways:

- A single byte write shows whether data lands at the address that was sent.
- A 17-byte page write that starts partway into a page separates a correct in-page wrap from a carry into the next page, and from first-write-wins buffering.
- A write cut short by a repeated start, and a write made with the supply low, separate "buffered" from "committed".

Select bytes are also probed right after a committing stop and again shortly before the write cycle ends, which tests the length of the busy window. On the read side, current-address, random and sequential reads across a page edge and across the top of the array separate a full-width address increment from a page-limited one.

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int         ADDR_W     = 8,
  parameter int         PAGE_BYTES = 16,
  parameter int         WR_CYCLES  = 500000,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic supply_ok,
  output logic sda_pull
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int BW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_TX, S_MACK
  } st_t;

  logic [2:0] scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  logic [7:0]             mem  [DEPTH];
  logic [7:0]             wbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  wvalid;
  logic [ADDR_W-PW-1:0]   wpage;
  logic [ADDR_W-1:0]      addr;
  logic [7:0]             sh, tx;
  logic [3:0]             cnt;
  logic                   rw, mack;
  logic [BW-1:0]          busy_cnt;
  st_t                    st;

  wire busy    = busy_cnt != '0;
  wire load_tx = scl_fall && ((st == S_DEV_ACK && rw) || (st == S_MACK && mack));
  wire rx_st   = (st == S_DEV) || (st == S_ADDR) || (st == S_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) wbuf[i] <= '0;
      wvalid   <= '0;
      wpage    <= '0;
      addr     <= '0;
      sh       <= '0;
      tx       <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      busy_cnt <= '0;
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (busy) begin
      busy_cnt <= busy_cnt - BW'(1);
      st       <= S_IDLE;
      sda_pull <= 1'b0;
      wvalid   <= '0;
    end else if (stop_det) begin
      if ((st == S_WR || st == S_WR_ACK) && |wvalid && supply_ok) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (wvalid[i]) mem[{wpage, PW'(i)}] <= wbuf[i];
        busy_cnt <= BW'(WR_CYCLES);
      end
      st       <= S_IDLE;
      sda_pull <= 1'b0;
      wvalid   <= '0;
    end else if (start_det) begin
      st       <= S_DEV;
      cnt      <= '0;
      sda_pull <= 1'b0;
      wvalid   <= '0;
    end else if (load_tx) begin
      tx       <= {mem[addr][6:0], 1'b0};
      sda_pull <= ~mem[addr][7];
      addr     <= addr + ADDR_W'(1);
      cnt      <= 4'd1;
      st       <= S_TX;
    end else if (rx_st) begin
      if (scl_rise) begin
        sh  <= {sh[6:0], sda_q[1]};
        cnt <= cnt + 4'd1;
      end else if (scl_fall && cnt == 4'd8) begin
        cnt <= '0;
        if (st == S_DEV) begin
          if (sh[7:4] == DEV_PREFIX) begin
            rw       <= sh[0];
            sda_pull <= 1'b1;
            st       <= S_DEV_ACK;
          end else st <= S_IDLE;
        end else if (st == S_ADDR) begin
          addr     <= ADDR_W'(sh);
          sda_pull <= 1'b1;
          st       <= S_ADDR_ACK;
        end else begin
          wbuf[addr[PW-1:0]]   <= sh;
          wvalid[addr[PW-1:0]] <= 1'b1;
          wpage                <= addr[ADDR_W-1:PW];
          addr                 <= {addr[ADDR_W-1:PW], addr[PW-1:0] + PW'(1)};
          sda_pull             <= 1'b1;
          st                   <= S_WR_ACK;
        end
      end
    end else begin
      case (st)
        S_DEV_ACK: if (scl_fall) begin sda_pull <= 1'b0; st <= S_ADDR; end
        S_ADDR_ACK, S_WR_ACK: if (scl_fall) begin sda_pull <= 1'b0; st <= S_WR; end
        S_TX: if (scl_fall) begin
          if (cnt == 4'd8) begin
            sda_pull <= 1'b0;
            mack     <= 1'b0;
            st       <= S_MACK;
          end else begin
            sda_pull <= ~tx[7];
            tx       <= {tx[6:0], 1'b0};
            cnt      <= cnt + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= ~sda_q[1];
          if (scl_fall) st <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  a_r6_cycle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  a_r7_supply_gates_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(supply_ok));

  a_r11_pull_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_q[1]));

  a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR_ACK && $past(st) == S_WR) |-> addr[ADDR_W-1:PW] == $past(addr[ADDR_W-1:PW]));

  a_r12_release_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_MACK && st == S_IDLE) |-> !sda_pull);
endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
  localparam int WRC = 3000;
  localparam int Q   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, supply_ok = 1'b0;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  serial_eeprom_slave #(.WR_CYCLES(WRC)) u_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .supply_ok(supply_ok), .sda_pull(sda_pull));

  int checks = 0, errors = 0;
  int exp_q[$], obs_q[$];
  string tag_q[$];
  logic [7:0] em [256];
  logic [7:0] cur = 8'h00;
  int viol = 0;
  logic pull_d = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (sda_pull && !pull_d && scl_m) viol++;
    pull_d <= sda_pull;
  end

  task automatic expect_item(string tag, int v);
    tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  task automatic observe(int v);
    obs_q.push_back(v);
  endtask

  initial forever begin
    int o, e;
    string t;
    wait (obs_q.size() > 0);
    o = obs_q.pop_front();
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected item: actual %0h expected none", o);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (o !== e) begin
        errors++;
        $display("FAIL %s: actual %0h expected %0h", t, o, e);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_out(logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q / 2); b = sda_line; tick(Q / 2); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_chk(string tag, logic [7:0] d, logic exp_ack);
    logic b;
    expect_item(tag, int'(exp_ack));
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    observe(int'(!b));
  endtask

  task automatic recv_chk(string tag, logic [7:0] e, logic ack);
    logic [7:0] v;
    logic b;
    expect_item(tag, int'(e));
    for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
    bit_out(!ack);
    observe(int'(v));
  endtask

  task automatic write_bytes(string tag, logic [7:0] a, int n, logic [7:0] base);
    bstart();
    send_chk(tag, 8'hA0, 1'b1);
    send_chk(tag, a, 1'b1);
    for (int i = 0; i < n; i++) send_chk(tag, base + 8'(i), 1'b1);
    bstop();
    if (supply_ok)
      for (int i = 0; i < n; i++) em[{a[7:4], 4'(a[3:0] + 4'(i))}] = base + 8'(i);
    cur = {a[7:4], 4'(a[3:0] + 4'(n))};
  endtask

  task automatic seq_out(string tag, int n);
    for (int k = 0; k < n; k++) begin
      recv_chk(tag, em[cur], k < n - 1);
      cur = cur + 8'd1;
    end
    expect_item("R12", 0);
    observe(int'(sda_pull));
    bstop();
  endtask

  task automatic rand_read(string tag, logic [7:0] a, int n);
    bstart();
    send_chk(tag, 8'hA0, 1'b1);
    send_chk(tag, a, 1'b1);
    bstart();
    send_chk(tag, 8'hA1, 1'b1);
    cur = a;
    seq_out(tag, n);
  endtask

  task automatic cur_read(string tag, int n);
    bstart();
    send_chk(tag, 8'hA1, 1'b1);
    seq_out(tag, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) em[i] = 8'h00;
    tick(5);
    expect_item("R1", 0); observe(int'(sda_pull));
    rst_n = 1'b1;
    tick(3);
    expect_item("R1", 0); observe(int'(sda_pull));
    supply_ok = 1'b1;
    tick(5);

    // R3, R9: single byte write then random read
    write_bytes("R3", 8'h10, 1, 8'h5A);
    tick(WRC + 100);
    rand_read("R9", 8'h10, 1);

    // R2: don't-care select bits, wrong prefix, bytes after wrong prefix ignored
    bstart(); send_chk("R2", 8'hAE, 1'b1); bstop();
    bstart(); send_chk("R2", 8'hB0, 1'b0); send_chk("R2", 8'h55, 1'b0); bstop();

    // R4, R10: 17-byte page write from mid-page, then read across page edge
    write_bytes("R4", 8'h2C, 17, 8'h80);
    tick(WRC + 100);
    rand_read("R4", 8'h20, 17);

    // R8: current address read after a random read
    rand_read("R8", 8'h24, 1);
    cur_read("R8", 2);

    // R5: repeated start discards write data and starts no cycle
    bstart();
    send_chk("R5", 8'hA0, 1'b1);
    send_chk("R5", 8'h40, 1'b1);
    send_chk("R5", 8'h11, 1'b1);
    bstart();
    send_chk("R5", 8'hA1, 1'b1);
    cur = 8'h41;
    seq_out("R5", 1);
    rand_read("R5", 8'h40, 1);

    // R6: busy window after a committing stop
    write_bytes("R6", 8'h50, 1, 8'h77);
    bstart(); send_chk("R6", 8'hA0, 1'b0); bstop();
    tick(WRC - 900);
    bstart(); send_chk("R6", 8'hA0, 1'b0); bstop();
    tick(600);
    rand_read("R6", 8'h50, 1);

    // R7: supply low blocks the commit and the write cycle
    supply_ok = 1'b0;
    write_bytes("R7", 8'h60, 1, 8'h33);
    supply_ok = 1'b1;
    rand_read("R7", 8'h60, 1);

    // R10: wrap from top of the array to address zero
    write_bytes("R10", 8'hFF, 1, 8'hEE);
    tick(WRC + 100);
    write_bytes("R10", 8'h00, 1, 8'h01);
    tick(WRC + 100);
    rand_read("R10", 8'hFF, 2);

    expect_item("R11", 0); observe(viol);

    wait (obs_q.size() == 0);
    tick(2);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule